// File: doc/BRIEF.md
# PS/2 Host Serial Link Engine

This block is the host end of a two-wire, open-drain keyboard or mouse link in which the attached device always generates the clock. In the background it receives frames from the device. Each frame is a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1. A received frame is delivered as a byte, together with an error flag that covers parity and framing. A frame with a bad parity bit or a stop bit of 0 is still delivered, with its error flag set.

To send a command byte, a requester presents it on a valid/ready handshake. The engine first lets any device frame already in progress complete. It then holds the clock line low for a programmable minimum time and drives the data line low as the start bit. Next it releases the clock and shifts the data bits, the parity bit and the stop bit out on the falling edges of the device clock. On the eleventh falling edge it samples the device's acknowledge.

The pads are modelled as pairs: a line input and an output enable. When the enable is high, the pad pulls the line low. Both line inputs pass through two synchronising flops. Only clock transitions that stay stable for several system clocks are accepted. A watchdog ends any receive or send that stalls between clock edges and reports a timeout.

Top module: `ps2_host_link`

## Requirements
- R1: After reset neither line is pulled low, `tx_ready` is 1, and `rx_valid`, `tx_done` and `timeout_err` are 0.
- R2: A device frame is captured least significant bit first. `rx_valid` pulses for one cycle after the stop bit, with the byte on `rx_data`.
- R3: `rx_err` is 1 when the parity bit does not make the count of ones in data plus parity odd, or when the stop bit is 0. The byte is still delivered.
- R4: For a send, the clock line is held low for at least `INHIBIT_CYC` system clocks before the data line is pulled low.
- R5: The data line is pulled low as the start bit while the clock is still held. The clock is released only while the start bit is being driven, and the host does not drive the clock again for the rest of the send.
- R6: The bits the device samples on its rising edges are the eight data bits with the least significant bit first, then odd parity, then a released line (stop = 1). For example, byte EDh gives 1,0,1,1,0,1,1,1, then parity 1, then stop 1.
- R7: On the eleventh falling clock edge of a send, the data line is sampled. `tx_done` pulses with `tx_ack` = 1 when the line is low and 0 when it is high, and both lines are released.
- R8: A send requested while a device frame is in progress does not pull the clock low before that frame's stop bit. The frame is still received.
- R9: A low pulse on the clock line shorter than `FILTER_LEN` system clocks is not treated as an edge.
- R10: If no falling clock edge arrives within `TIMEOUT_CYC` system clocks during a receive or a send, `timeout_err` pulses, both lines are released, the partial frame is discarded, and an aborted send is dropped (`tx_ready` returns to 1).
- R11: A byte is accepted when `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until `tx_done` or a send timeout, and `tx_valid` is ignored in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Command byte offered |
| tx_data | input | 8 | Command byte |
| tx_ready | output | 1 | Engine can take a command byte |
| tx_done | output | 1 | One-cycle pulse when a send finishes |
| tx_ack | output | 1 | Device acknowledged (valid with tx_done) |
| rx_valid | output | 1 | One-cycle pulse when a device frame is complete |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | Parity or stop-bit error on the received frame |
| timeout_err | output | 1 | One-cycle pulse when a stalled frame is aborted |
| ps2_clk_i | input | 1 | Clock line level |
| ps2_clk_oe | output | 1 | Pull the clock line low |
| ps2_dat_i | input | 1 | Data line level |
| ps2_dat_oe | output | 1 | Pull the data line low |

## Verification
The assertions assume that the device changes the data line only while the clock is high, and that each clock low phase lasts longer than the synchroniser and filter delay. They also assume that the clock line returns high once the host releases it. The bench device model toggles data in the middle of the clock-high phase and uses low phases several times longer than `FILTER_LEN`. The only short pulse it produces is the deliberate glitch. The model treats the lines as wired-AND of the host and device enables, so released lines read high.

// File: rtl/ps2_host_link.sv
module ps2_host_link #(
  parameter int INHIBIT_CYC = 12000,
  parameter int TIMEOUT_CYC = 400000,
  parameter int FILTER_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       tx_ack,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_err,
  output logic       timeout_err,
  input  logic       ps2_clk_i,
  output logic       ps2_clk_oe,
  input  logic       ps2_dat_i,
  output logic       ps2_dat_oe
);
  localparam int IW = $clog2(INHIBIT_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int WW = (IW > TW) ? IW : TW;
  localparam int FW = $clog2(FILTER_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_INH, S_STRT, S_TX} st_t;

  st_t          st;
  logic [1:0]   csync, dsync;
  logic         fclk, fall;
  logic [FW-1:0] fcnt;
  logic [WW-1:0] wcnt;
  logic [3:0]   bcnt;
  logic [7:0]   rsh, tbuf;
  logic         rpar, pend;
  logic [10:0]  tsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csync <= 2'b11;
      dsync <= 2'b11;
    end else begin
      csync <= {csync[0], ps2_clk_i};
      dsync <= {dsync[0], ps2_dat_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fclk <= 1'b1;
      fcnt <= '0;
      fall <= 1'b0;
    end else begin
      fall <= 1'b0;
      if (csync[1] == fclk) begin
        fcnt <= '0;
      end else if (fcnt == FW'(FILTER_LEN - 1)) begin
        fclk <= csync[1];
        fcnt <= '0;
        fall <= fclk;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  wire stalled = (wcnt == WW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      wcnt        <= '0;
      bcnt        <= '0;
      rsh         <= '0;
      rpar        <= 1'b0;
      tbuf        <= '0;
      tsh         <= '1;
      pend        <= 1'b0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      rx_err      <= 1'b0;
      tx_done     <= 1'b0;
      tx_ack      <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      tx_done     <= 1'b0;
      timeout_err <= 1'b0;
      if (tx_valid && !pend) begin
        pend <= 1'b1;
        tbuf <= tx_data;
      end
      case (st)
        S_IDLE: begin
          wcnt <= '0;
          bcnt <= '0;
          if (pend) st <= S_INH;
          else if (fall && !dsync[1]) st <= S_RX;
        end
        S_RX: begin
          if (fall) begin
            wcnt <= '0;
            bcnt <= bcnt + 1'b1;
            if (bcnt < 4'd8) begin
              rsh <= {dsync[1], rsh[7:1]};
            end else if (bcnt == 4'd8) begin
              rpar <= dsync[1];
            end else begin
              rx_valid <= 1'b1;
              rx_data  <= rsh;
              rx_err   <= !(^{rsh, rpar}) || !dsync[1];
              st       <= S_IDLE;
            end
          end else if (stalled) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_INH: begin
          if (wcnt == WW'(INHIBIT_CYC - 1)) begin
            wcnt <= '0;
            tsh  <= {1'b1, ~^tbuf, tbuf, 1'b0};
            st   <= S_STRT;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_STRT: begin
          wcnt <= '0;
          bcnt <= '0;
          st   <= S_TX;
        end
        S_TX: begin
          if (fall) begin
            wcnt <= '0;
            if (bcnt == 4'd10) begin
              tx_done <= 1'b1;
              tx_ack  <= !dsync[1];
              pend    <= 1'b0;
              st      <= S_IDLE;
            end else begin
              tsh  <= {1'b1, tsh[10:1]};
              bcnt <= bcnt + 1'b1;
            end
          end else if (stalled) begin
            timeout_err <= 1'b1;
            pend        <= 1'b0;
            st          <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_ready   = !pend;
  assign ps2_clk_oe = (st == S_INH) || (st == S_STRT);
  assign ps2_dat_oe = ((st == S_STRT) || (st == S_TX)) && !tsh[0];

  logic [IW:0] hold_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hold_cnt <= '0;
    else        hold_cnt <= ps2_clk_oe ? hold_cnt + 1'b1 : '0;
  end

  p_inhibit_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> (int'(hold_cnt) >= INHIBIT_CYC));

  p_release_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_dat_oe);

  p_busy_after_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_done_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!ps2_clk_oe && !ps2_dat_oe && tx_ready));

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, tx_done, timeout_err}));

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!ps2_clk_oe && !ps2_dat_oe));
endmodule

// File: tb/test_ps2_host_link.sv
`timescale 1ns/1ps
module test_ps2_host_link;
  localparam int INH  = 40;
  localparam int TO   = 400;
  localparam int FL   = 4;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, tx_done, tx_ack, rx_valid, rx_err, timeout_err;
  logic [7:0] rx_data;
  logic       ps2_clk_oe, ps2_dat_oe;
  logic       dev_clk_oe = 1'b0, dev_dat_oe = 1'b0, dev_busy = 1'b0;
  wire        clk_line = !(ps2_clk_oe || dev_clk_oe);
  wire        dat_line = !(ps2_dat_oe || dev_dat_oe);

  ps2_host_link #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TO), .FILTER_LEN(FL)) i_ps2_host_link (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_done(tx_done), .tx_ack(tx_ack), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .timeout_err(timeout_err), .ps2_clk_i(clk_line), .ps2_clk_oe(ps2_clk_oe),
    .ps2_dat_i(dat_line), .ps2_dat_oe(ps2_dat_oe));

  int checks = 0, failures = 0, exp_to = 0, ihold = 0;
  logic [8:0] exp_rx[$];
  bit         exp_ack[$];
  bit         prev_clk = 1'b0, prev_dat = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dev_send(input logic [7:0] b, input bit bad_par, input bit bad_stop, input int nbits);
    logic [10:0] bits;
    bits = {!bad_stop, (~^b) ^ bad_par, b, 1'b0};
    if (nbits == 11) exp_rx.push_back({bad_par | bad_stop, b});
    dev_busy = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      dev_dat_oe = !bits[i];
      repeat (HALF / 2) @(negedge clk);
      dev_clk_oe = 1'b1;
      if (i == 10) dev_busy = 1'b0;
      repeat (HALF) @(negedge clk);
      dev_clk_oe = 1'b0;
      repeat (HALF / 2) @(negedge clk);
    end
    dev_dat_oe = 1'b0;
    dev_busy = 1'b0;
  endtask

  task automatic dev_recv(input bit give_ack, output logic [9:0] got);
    got = '0;
    wait (clk_line == 1'b0 && dat_line == 1'b0);
    wait (clk_line == 1'b1);
    for (int k = 0; k < 11; k++) begin
      repeat (HALF / 2) @(negedge clk);
      if (k == 10) dev_dat_oe = give_ack;
      dev_clk_oe = 1'b1;
      repeat (HALF) @(negedge clk);
      dev_clk_oe = 1'b0;
      if (k < 10) got[k] = dat_line;
      repeat (HALF / 2) @(negedge clk);
    end
    dev_dat_oe = 1'b0;
  endtask

  task automatic host_req(input logic [7:0] b);
    @(negedge clk);
    check(tx_ready == 1'b1, "R11", tx_ready, 1);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rx_valid) begin
        if (exp_rx.size() == 0) check(1'b0, "R2", {rx_err, rx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_rx.pop_front();
          check({rx_err, rx_data} == e, e[8] ? "R3" : "R2", {rx_err, rx_data}, e);
        end
      end
      if (tx_done) begin
        if (exp_ack.size() == 0) check(1'b0, "R7", tx_ack, 0);
        else begin
          bit a;
          a = exp_ack.pop_front();
          check(tx_ack == a, "R7", tx_ack, a);
        end
      end
      if (timeout_err) begin
        check(exp_to > 0, "R10", 1, exp_to);
        if (exp_to > 0) exp_to--;
      end
      if (dev_busy && ps2_clk_oe) check(1'b0, "R8", 1, 0);
      if (ps2_dat_oe && !prev_dat && ps2_clk_oe) check(ihold >= INH, "R4", ihold, INH);
      if (!ps2_clk_oe && prev_clk) check(ps2_dat_oe == 1'b1, "R5", ps2_dat_oe, 1);
      ihold    = ps2_clk_oe ? ihold + 1 : 0;
      prev_clk = ps2_clk_oe;
      prev_dat = ps2_dat_oe;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready && !ps2_clk_oe && !ps2_dat_oe, "R1", {tx_ready, ps2_clk_oe, ps2_dat_oe}, 3'b100);
    check(!rx_valid && !tx_done && !timeout_err, "R1", {rx_valid, tx_done, timeout_err}, 0);

    // R2 reception, several patterns
    dev_send(8'hA5, 0, 0, 11);
    dev_send(8'h00, 0, 0, 11);
    dev_send(8'hFF, 0, 0, 11);
    repeat (50) @(negedge clk);
    // R3 parity and stop errors
    dev_send(8'h5C, 1, 0, 11);
    dev_send(8'h13, 0, 1, 11);
    repeat (50) @(negedge clk);

    // R6 / R7 send EDh with acknowledge
    exp_ack.push_back(1'b1);
    host_req(8'hED);
    dev_recv(1'b1, got);
    check(got[7:0] == 8'hED, "R6", got[7:0], 8'hED);
    check(got[8] == 1'b1 && got[9] == 1'b1, "R6", got[9:8], 2'b11);
    repeat (50) @(negedge clk);

    // R7 missing acknowledge
    exp_ack.push_back(1'b0);
    host_req(8'h00);
    dev_recv(1'b0, got);
    check(got[7:0] == 8'h00 && got[8] == 1'b1, "R6", got[8:0], 9'h100);
    repeat (50) @(negedge clk);

    // R11 second request while busy is ignored
    exp_ack.push_back(1'b1);
    host_req(8'hC3);
    tx_valid = 1'b1;
    tx_data  = 8'h99;
    repeat (5) @(negedge clk);
    check(tx_ready == 1'b0, "R11", tx_ready, 0);
    tx_valid = 1'b0;
    dev_recv(1'b1, got);
    check(got[7:0] == 8'hC3, "R11", got[7:0], 8'hC3);
    repeat (150) @(negedge clk);
    check(!ps2_clk_oe && tx_ready, "R11", {ps2_clk_oe, tx_ready}, 2'b01);

    // R8 deferral behind a device frame
    exp_ack.push_back(1'b1);
    fork
      dev_send(8'h3C, 0, 0, 11);
      begin
        repeat (150) @(negedge clk);
        host_req(8'h5A);
        check(ps2_clk_oe == 1'b0, "R8", ps2_clk_oe, 0);
      end
    join
    dev_recv(1'b1, got);
    check(got[7:0] == 8'h5A, "R8", got[7:0], 8'h5A);
    repeat (50) @(negedge clk);

    // R9 glitch on clock with data low
    dev_dat_oe = 1'b1;
    repeat (5) @(negedge clk);
    dev_clk_oe = 1'b1;
    repeat (FL - 2) @(negedge clk);
    dev_clk_oe = 1'b0;
    repeat (5) @(negedge clk);
    dev_dat_oe = 1'b0;
    repeat (100) @(negedge clk);
    check(exp_rx.size() == 0 && !rx_valid, "R9", exp_rx.size(), 0);
    dev_send(8'h81, 0, 0, 11);
    repeat (50) @(negedge clk);

    // R10 receive stalls mid-frame
    exp_to++;
    dev_send(8'h77, 0, 0, 4);
    repeat (TO + 100) @(negedge clk);
    check(exp_to == 0, "R10", exp_to, 0);
    dev_send(8'h42, 0, 0, 11);
    repeat (50) @(negedge clk);

    // R10 send with no device clock
    exp_to++;
    host_req(8'h12);
    repeat (INH + TO + 100) @(negedge clk);
    check(exp_to == 0, "R10", exp_to, 0);
    check(tx_ready && !ps2_clk_oe && !ps2_dat_oe, "R10", {tx_ready, ps2_clk_oe, ps2_dat_oe}, 3'b100);

    repeat (100) @(negedge clk);
    check(exp_rx.size() == 0, "R2", exp_rx.size(), 0);
    check(exp_ack.size() == 0, "R7", exp_ack.size(), 0);
    finish_run();
  end
endmodule